// File: doc/BRIEF.md
# Card Socket Status and Identification Registers

This block is a small word-addressed register file that sits beside a removable memory card socket. It returns two fixed identification words, and it holds an interrupt register with two live bits. The write-protect bit follows the socket's write-protect switch. The card-present bit is set when a card is detected and stays set until software releases it.

An interrupt output follows the card-present bit. Software therefore sees an interrupt when a card goes in, reads the register to learn the card state, and writes a one to the card-present bit to acknowledge the event. Both socket inputs are asynchronous and pass through a synchronizer of configurable depth (two flip-flops by default) before the register logic uses them.

Reads are registered. A read strobe loads the read data port at the next clock edge, and the port holds that value until the next read. Writes to the flash-programming word and to the decode word are accepted and have no effect. Offsets that are not decoded read as zero and ignore writes.

Top module: `card_socket_regs`

## Requirements
- R1: After reset the interrupt register is zero, `cardIrq` is low and `busRdData` is zero.
- R2: A read of word index 0 returns 0x41034003, a read of index 3 returns 0x00000011, and a read of index 1 returns zero.
- R3: Bit 0 of the interrupt register (word index 2) equals the `wpIn` level as it was two clock edges earlier, and it tracks that level in both directions.
- R4: Bit 3 of the interrupt register is set once a synchronized high level on `detectIn` is seen. It stays set after `detectIn` returns low.
- R5: A write to index 2 with bit 3 high clears bit 3. Writes to index 2 with bit 3 low, whatever the other bits hold (bit 0 included), leave the register unchanged.
- R6: When the synchronized `detectIn` is high in the same cycle as a clearing write, bit 3 remains set.
- R7: `cardIrq` equals bit 3 of the interrupt register. It rises only after a detected insertion and falls when software clears the bit.
- R8: Writes to indices 0, 1 and 3, and to any index other than 2, change no readable state. Every index other than 0 to 3 reads zero.
- R9: `busRdData` takes its new value one clock edge after a cycle with `busRdEn` high, and it holds that value while `busRdEn` stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| busAddr | input | ADDR_W (6) | Word index of the access |
| busWrEn | input | 1 | Write strobe, one cycle per write |
| busWrData | input | DATA_W (32) | Write data |
| busRdEn | input | 1 | Read strobe, one cycle per read |
| busRdData | output | DATA_W (32) | Registered read data, held between reads |
| wpIn | input | 1 | Asynchronous write-protect switch level |
| detectIn | input | 1 | Asynchronous card-detect level |
| cardIrq | output | 1 | Interrupt, high while the card-present bit is set |

## Verification
The bench checks that the card-present bit survives the detect input falling. A design that treated the bit as a plain level would read zero there and drop the interrupt. It writes index 2 with only bit 0 set, and again with every bit except bit 3 set. A design that decoded the wrong bit position would lose the card-present bit on one of these writes. It holds detect high through a clearing write to confirm that the set wins; a clear-first design would drop the interrupt for a cycle and read zero. It also writes to the identification, flash, decode and undecoded words and reads back, to catch address decoding that aliases onto the interrupt register.

// File: rtl/csr_pkg.sv
package csr_pkg;
  localparam logic [31:0] ID_WORD     = 32'h4103_4003;
  localparam logic [31:0] DECODE_WORD = 32'h0000_0011;
  localparam int WP_POS    = 0;
  localparam int CARD_POS  = 3;
  localparam int IDX_ID    = 0;
  localparam int IDX_FLASH = 1;
  localparam int IDX_INT   = 2;
  localparam int IDX_DEC   = 3;

  typedef enum logic [1:0] {
    SRC_ZERO = 2'd0,
    SRC_ID   = 2'd1,
    SRC_INT  = 2'd2,
    SRC_DEC  = 2'd3
  } rdSrc_e;

  typedef struct packed {
    logic   rdLoad;
    rdSrc_e rdSrc;
    logic   clrCard;
  } strobe_t;
endpackage

// File: rtl/csr_sync.sv
module csr_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic asyncIn,
  output logic syncOut
);
  logic [STAGES-1:0] chain;

  generate
    for (genvar i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (!rstN) chain[0] <= 1'b0;
          else       chain[0] <= asyncIn;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (!rstN) chain[i] <= 1'b0;
          else       chain[i] <= chain[i-1];
        end
      end
    end
  endgenerate

  assign syncOut = chain[STAGES-1];
endmodule

// File: rtl/csr_ctrl.sv
module csr_ctrl
  import csr_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWrEn,
  input  logic [DATA_W-1:0] busWrData,
  input  logic              busRdEn,
  output strobe_t           strb
);
  localparam logic [DATA_W-1:0] CARD_MASK = DATA_W'(1) << CARD_POS;

  logic hitInt;
  assign hitInt = (busAddr == ADDR_W'(IDX_INT));

  always_comb begin
    strb         = '0;
    strb.rdLoad  = busRdEn;
    strb.clrCard = busWrEn && hitInt && (|(busWrData & CARD_MASK));
    if (busAddr == ADDR_W'(IDX_ID))       strb.rdSrc = SRC_ID;
    else if (hitInt)                       strb.rdSrc = SRC_INT;
    else if (busAddr == ADDR_W'(IDX_DEC)) strb.rdSrc = SRC_DEC;
    else                                   strb.rdSrc = SRC_ZERO;
  end

  // R8: a write away from the interrupt word never clears the card bit
  p_other_write_r8: assert property (@(posedge clk) disable iff (!rstN)
    (busWrEn && !hitInt) |-> !strb.clrCard);
  // R5: a write with bit 3 low never clears
  p_bit3_low_r5: assert property (@(posedge clk) disable iff (!rstN)
    (busWrEn && !busWrData[CARD_POS]) |-> !strb.clrCard);
endmodule

// File: rtl/csr_datapath.sv
module csr_datapath
  import csr_pkg::*;
#(
  parameter int DATA_W      = 32,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           strb,
  input  logic              wpIn,
  input  logic              detectIn,
  output logic [DATA_W-1:0] rdData,
  output logic              cardIrq
);
  logic wpSync, detSync, cardLatched;
  logic [DATA_W-1:0] intWord, rdNext;

  csr_sync #(.STAGES(SYNC_STAGES)) i_wpSync (
    .clk(clk), .rstN(rstN), .asyncIn(wpIn), .syncOut(wpSync));
  csr_sync #(.STAGES(SYNC_STAGES)) i_detSync (
    .clk(clk), .rstN(rstN), .asyncIn(detectIn), .syncOut(detSync));

  // sticky card-present bit: set wins over a same-cycle clear
  always_ff @(posedge clk) begin
    if (!rstN)              cardLatched <= 1'b0;
    else if (detSync)       cardLatched <= 1'b1;
    else if (strb.clrCard)  cardLatched <= 1'b0;
  end

  always_comb begin
    intWord           = '0;
    intWord[WP_POS]   = wpSync;
    intWord[CARD_POS] = cardLatched;
  end

  always_comb begin
    unique case (strb.rdSrc)
      SRC_ID:  rdNext = DATA_W'(ID_WORD);
      SRC_INT: rdNext = intWord;
      SRC_DEC: rdNext = DATA_W'(DECODE_WORD);
      default: rdNext = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN)            rdData <= '0;
    else if (strb.rdLoad) rdData <= rdNext;
  end

  assign cardIrq = cardLatched;

  // cycles since reset, saturating, for the history-based check
  logic [1:0] upCnt;
  always_ff @(posedge clk) begin
    if (!rstN)              upCnt <= '0;
    else if (upCnt != 2'd3) upCnt <= upCnt + 2'd1;
  end

  // R4: the card bit holds unless a clear arrives
  p_sticky_r4: assert property (@(posedge clk) disable iff (!rstN)
    (cardLatched && !strb.clrCard) |=> cardLatched);
  // R6: a synchronized detect always leaves the bit set
  p_set_wins_r6: assert property (@(posedge clk) disable iff (!rstN)
    detSync |=> cardLatched);
  // R5: a clear without a detect drops the bit
  p_clear_r5: assert property (@(posedge clk) disable iff (!rstN)
    (strb.clrCard && !detSync) |=> !cardLatched);
  // R7: the interrupt only rises after a detect
  p_irq_rise_r7: assert property (@(posedge clk) disable iff (!rstN)
    $rose(cardIrq) |-> $past(detSync));
  // R9: read data is stable between reads
  p_rd_hold_r9: assert property (@(posedge clk) disable iff (!rstN)
    !strb.rdLoad |=> $stable(rdData));
  // R3: the write-protect bit follows its input two edges late
  p_wp_track_r3: assert property (@(posedge clk) disable iff (!rstN)
    (SYNC_STAGES == 2 && upCnt == 2'd3) |-> (intWord[WP_POS] == $past(wpIn, 2)));
endmodule

// File: rtl/card_socket_regs.sv
module card_socket_regs
  import csr_pkg::*;
#(
  parameter int ADDR_W      = 6,
  parameter int DATA_W      = 32,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWrEn,
  input  logic [DATA_W-1:0] busWrData,
  input  logic              busRdEn,
  output logic [DATA_W-1:0] busRdData,
  input  logic              wpIn,
  input  logic              detectIn,
  output logic              cardIrq
);
  strobe_t strb;

  csr_ctrl #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) i_ctrl (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWrEn(busWrEn),
    .busWrData(busWrData), .busRdEn(busRdEn), .strb(strb));

  csr_datapath #(.DATA_W(DATA_W), .SYNC_STAGES(SYNC_STAGES)) i_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .wpIn(wpIn), .detectIn(detectIn),
    .rdData(busRdData), .cardIrq(cardIrq));

  // R1: nothing is pending straight out of reset
  p_reset_r1: assert property (@(posedge clk)
    !rstN |=> (!cardIrq && busRdData == '0));
endmodule

// File: tb/test_card_socket_regs.sv
module test_card_socket_regs;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [5:0]  busAddr = '0;
  logic        busWrEn = 1'b0;
  logic [31:0] busWrData = '0;
  logic        busRdEn = 1'b0;
  logic [31:0] busRdData;
  logic        wpIn = 1'b0;
  logic        detectIn = 1'b0;
  logic        cardIrq;

  localparam logic [31:0] ID_EXP  = 32'h4103_4003;
  localparam logic [31:0] DEC_EXP = 32'h0000_0011;

  card_socket_regs i_card_socket_regs (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWrEn(busWrEn),
    .busWrData(busWrData), .busRdEn(busRdEn), .busRdData(busRdData),
    .wpIn(wpIn), .detectIn(detectIn), .cardIrq(cardIrq));

  always #5 clk = ~clk;

  typedef struct {
    logic [31:0] val;
    string       tag;
  } expItem_t;
  expItem_t expQ[$];

  int nChecks = 0;
  int nFail = 0;
  bit finished = 1'b0;

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic doRead(int idx, logic [31:0] exp, string tag);
    expItem_t it;
    @(negedge clk);
    busAddr = 6'(idx);
    busRdEn = 1'b1;
    it.val = exp;
    it.tag = tag;
    expQ.push_back(it);
    @(negedge clk);
    busRdEn = 1'b0;
  endtask

  task automatic doWrite(int idx, logic [31:0] data);
    @(negedge clk);
    busAddr   = 6'(idx);
    busWrData = data;
    busWrEn   = 1'b1;
    @(negedge clk);
    busWrEn   = 1'b0;
  endtask

  // monitor: compare read data one edge after each read strobe
  initial begin
    forever begin
      @(posedge clk);
      if (busRdEn) begin
        #2;
        if (expQ.size() == 0) begin
          chk("R9 unexpected read", busRdData, 32'h0);
        end else begin
          expItem_t it;
          it = expQ.pop_front();
          chk(it.tag, busRdData, it.val);
        end
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      nChecks++;
      nFail++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
      $finish;
    end
  end

  initial begin
    idle(3);
    rstN = 1'b1;
    @(negedge clk);
    chk("R1 irq", 32'(cardIrq), 32'h0);
    chk("R1 rdData", busRdData, 32'h0);
    doRead(2, 32'h0, "R1 intreg");

    doRead(0, ID_EXP, "R2 id word");
    doRead(3, DEC_EXP, "R2 decode word");
    doRead(1, 32'h0, "R2 flash word");

    // R9 hold
    doRead(0, ID_EXP, "R9 load");
    idle(3);
    chk("R9 hold", busRdData, ID_EXP);

    // R3 write-protect tracking
    wpIn = 1'b1;
    idle(3);
    doRead(2, 32'h1, "R3 wp high");
    wpIn = 1'b0;
    idle(3);
    doRead(2, 32'h0, "R3 wp low");

    // R4 sticky set
    detectIn = 1'b1;
    idle(2);
    detectIn = 1'b0;
    idle(4);
    doRead(2, 32'h8, "R4 sticky after detect low");
    chk("R7 irq high", 32'(cardIrq), 32'h1);

    // R5 writes that must not clear
    doWrite(2, 32'h1);
    doRead(2, 32'h8, "R5 bit0 write ignored");
    doWrite(2, 32'hFFFF_FFF7);
    doRead(2, 32'h8, "R5 other bits ignored");

    // R8 writes elsewhere never clear the card bit
    doWrite(6, 32'hFFFF_FFFF);
    doWrite(3, 32'h8);
    doWrite(1, 32'h8);
    doRead(2, 32'h8, "R8 foreign writes keep bit");

    // R5 clear
    doWrite(2, 32'h8);
    idle(1);
    doRead(2, 32'h0, "R5 cleared");
    chk("R7 irq low", 32'(cardIrq), 32'h0);

    // R6 set wins over a same-cycle clear
    detectIn = 1'b1;
    idle(4);
    doWrite(2, 32'h8);
    chk("R6 irq held", 32'(cardIrq), 32'h1);
    doRead(2, 32'h8, "R6 set priority");
    detectIn = 1'b0;
    idle(4);
    doWrite(2, 32'h8);
    idle(1);
    doRead(2, 32'h0, "R6 clear after release");

    // R8 constant words ignore writes, undecoded words read zero
    doWrite(0, 32'h0);
    doWrite(1, 32'hFFFF_FFFF);
    doWrite(3, 32'h0);
    doWrite(7, 32'hFFFF_FFFF);
    doRead(0, ID_EXP, "R8 id unchanged");
    doRead(1, 32'h0, "R8 flash still zero");
    doRead(3, DEC_EXP, "R8 decode unchanged");
    doRead(7, 32'h0, "R8 index 7 zero");
    doRead(63, 32'h0, "R8 index 63 zero");

    idle(4);
    chk("R9 queue drained", 32'(expQ.size()), 32'h0);
    finished = 1'b1;
    $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
    $finish;
  end
endmodule